// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Clock-Out Override

This block is a six-pin general-purpose I/O port that sits on an 8-bit register bus. Software writes a pin-value latch and a per-pin direction register. The block turns them into an output level and an output enable for each pin, and the external pad logic uses both. The levels that come back from the pads pass through a two-stage synchronizer. A read of the value register then returns the synchronized level on input pins and the latched value on output pins.

The direction register also holds a clock-output enable in its top bit. While that bit is set, pin 2 becomes an output and carries a free-running clock supplied on a dedicated input. The direction bit for pin 2 then has no effect. The value latches have no reset, so software can load a value before it turns a pin into an output. The direction register, including the clock-output enable, clears on reset.

Top module: `gpc_port`

## Requirements
- R1: Writing a 1 to direction bit n (n = 0..5) drives `pad_oe[n]` high from the clock edge that ends the write. Writing a 0 drives it low, and the pin becomes an input.
- R2: An active-low reset clears all direction bits and the clock-output enable (bit 7), so every `pad_oe` bit is 0 after reset.
- R3: Reset leaves the six value latches unchanged. A value written before reset is still driven once the pins are made outputs again.
- R4: A write to the value register at offset 0x02 loads bits 5..0 into the latches. `pad_do[n]` follows latch n, and a read of offset 0x02 returns latch n for every output pin.
- R5: For a pin whose direction bit is 0, a read of offset 0x02 returns the synchronized level of `pad_di[n]`.
- R6: A change on `pad_di` appears in the read-back only after two rising clock edges. After one edge the read still shows the old level.
- R7: Bits 7 and 6 of offset 0x02 and bit 6 of offset 0x06 read as 0, and writes to them are ignored.
- R8: While bit 7 of offset 0x06 is 1, pin 2 has `pad_oe[2]` = 1 and `pad_do[2]` equal to `sysclk_i`, whatever direction bit 2 holds. Bit 7 reads back as written.
- R9: While the clock-output enable is set, a read of offset 0x02 returns latch bit 2 for pin 2.
- R10: A write to the value latches takes effect whatever the direction bits are, so a preloaded value appears on the pins when they are later made outputs.
- R11: Writes to any offset other than 0x02 and 0x06 change nothing, and reads of other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| sysclk_i | input | 1 | Clock routed to pin 2 when the clock-output enable is set |
| pad_di | input | 6 | Pin levels returned by the pads |
| pad_do | output | 6 | Per-pin output level |
| pad_oe | output | 6 | Per-pin output enable |

## Verification
The port is tried with all pins as outputs, all pins as inputs, and a split direction pattern in which both the latch value and the pin value are set to 1 on different pins. The split pattern exposes a read mux that selects on the wrong condition. A pin step is sampled at zero, one and two edges, which pins down the synchronizer depth exactly. The clock-override sequence sets pin 2's direction bit both ways under the enable, then clears the enable. This separates the override from the plain direction path and shows that pin 2 reads the latch, not the pad. A reset in the middle of the run, and writes to unused offsets, show that the latches survive reset and that address decoding is exact.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_VALUE = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h06;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_VALUE = 2'd1,
        SEL_DIR   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpc_decode.sv
module gpc_decode
    import gpc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == OFS_VALUE) begin
            sel = SEL_VALUE;
        end else if (addr == OFS_DIR) begin
            sel = SEL_DIR;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/gpc_sync.sv
module gpc_sync #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/gpc_regs.sv
module gpc_regs
    import gpc_pkg::*;
#(
    parameter int unsigned PINS       = 6,
    parameter int unsigned CLK_EN_BIT = BUS_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [PINS-1:0]  value_q,
    output logic [PINS-1:0]  dir_q,
    output logic             clkout_q
);

    logic wr_value;
    logic wr_dir;

    assign wr_value = wr && (sel == SEL_VALUE);
    assign wr_dir   = wr && (sel == SEL_DIR);

    // Value latches deliberately carry no reset.
    always_ff @(posedge clk) begin
        if (wr_value) begin
            value_q <= wdata[PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            clkout_q <= 1'b0;
        end else if (wr_dir) begin
            dir_q    <= wdata[PINS-1:0];
            clkout_q <= wdata[CLK_EN_BIT];
        end
    end

endmodule

// File: rtl/gpc_pinmux.sv
module gpc_pinmux #(
    parameter int unsigned PINS    = 6,
    parameter int unsigned CLK_PIN = 2
) (
    input  logic [PINS-1:0] value_q,
    input  logic [PINS-1:0] dir_q,
    input  logic            clkout_q,
    input  logic            sysclk_i,
    output logic [PINS-1:0] pad_do,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] drive_eff
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i == CLK_PIN) begin : g_alt
            assign pad_oe[i]    = clkout_q | dir_q[i];
            assign pad_do[i]    = clkout_q ? sysclk_i : value_q[i];
            assign drive_eff[i] = clkout_q | dir_q[i];
        end else begin : g_plain
            assign pad_oe[i]    = dir_q[i];
            assign pad_do[i]    = value_q[i];
            assign drive_eff[i] = dir_q[i];
        end
    end

endmodule

// File: rtl/gpc_port.sv
module gpc_port
    import gpc_pkg::*;
#(
    parameter int unsigned PINS    = 6,
    parameter int unsigned CLK_PIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              sysclk_i,
    input  logic [PINS-1:0]   pad_di,
    output logic [PINS-1:0]   pad_do,
    output logic [PINS-1:0]   pad_oe
);

    localparam int unsigned CLK_EN_BIT = BUS_W - 1;

    reg_sel_e        sel;
    logic [PINS-1:0] value_q;
    logic [PINS-1:0] dir_q;
    logic            clkout_q;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] drive_eff;

    gpc_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpc_regs #(
        .PINS       (PINS),
        .CLK_EN_BIT (CLK_EN_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata),
        .value_q  (value_q),
        .dir_q    (dir_q),
        .clkout_q (clkout_q)
    );

    gpc_sync #(
        .W (PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_di),
        .q     (pin_sync)
    );

    gpc_pinmux #(
        .PINS    (PINS),
        .CLK_PIN (CLK_PIN)
    ) u_pinmux (
        .value_q   (value_q),
        .dir_q     (dir_q),
        .clkout_q  (clkout_q),
        .sysclk_i  (sysclk_i),
        .pad_do    (pad_do),
        .pad_oe    (pad_oe),
        .drive_eff (drive_eff)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_VALUE: begin
                bus_rdata[PINS-1:0] = (drive_eff & value_q) | (~drive_eff & pin_sync);
            end
            SEL_DIR: begin
                bus_rdata[PINS-1:0]   = dir_q;
                bus_rdata[CLK_EN_BIT] = clkout_q;
            end
            default: begin
                bus_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/gpc_port_chk.sv
module gpc_port_chk
    import gpc_pkg::*;
#(
    parameter int unsigned PINS    = 6,
    parameter int unsigned CLK_PIN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              sysclk_i,
    input logic [PINS-1:0]   pad_do,
    input logic [PINS-1:0]   pad_oe
);

    localparam logic [PINS-1:0] OTHER_PINS = ~(PINS'(1) << CLK_PIN);

    // R2
    dir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    // R1
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR && !bus_wdata[BUS_W-1])
        |=> (pad_oe == $past(bus_wdata[PINS-1:0])));

    // R8
    clkout_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR && bus_wdata[BUS_W-1])
        |=> (pad_oe[CLK_PIN] && (pad_do[CLK_PIN] == sysclk_i)));

    // R4
    value_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_VALUE)
        |=> (((pad_do ^ $past(bus_wdata[PINS-1:0])) & OTHER_PINS) == '0));

    // R7
    value_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_VALUE) |-> (bus_rdata[BUS_W-1:PINS] == '0));

    // R7
    dir_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_DIR) |-> (bus_rdata[BUS_W-2:PINS] == '0));

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_DIR && bus_addr != OFS_VALUE) |-> (bus_rdata == '0));

endmodule

bind gpc_port gpc_port_chk #(
    .PINS    (PINS),
    .CLK_PIN (CLK_PIN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sysclk_i  (sysclk_i),
    .pad_do    (pad_do),
    .pad_oe    (pad_oe)
);

// File: tb/gpc_port_tb_top.sv
`timescale 1ns/1ps
module gpc_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sysclk = 1'b0;
    logic [5:0] pad_di = 6'h00;
    logic [5:0] pad_do;
    logic [5:0] pad_oe;

    typedef struct {
        logic [7:0] rd;
        logic [5:0] oe;
        logic [5:0] dout;
        logic [5:0] do_mask;
        bit         clk_pin;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    gpc_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sysclk_i  (sysclk),
        .pad_di    (pad_di),
        .pad_do    (pad_do),
        .pad_oe    (pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Routed clock toggles away from both clock edges.
    always @(posedge clk) begin
        #2 sysclk = ~sysclk;
    end

    // Monitor: pops one expected item per cycle and compares at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            bit bad;
            it = sb_q.pop_front();
            vectors++;
            bad = 1'b0;
            if (bus_rdata !== it.rd) begin
                $display("FAIL %s: rdata actual %02h expected %02h", it.tag, bus_rdata, it.rd);
                bad = 1'b1;
            end
            if (pad_oe !== it.oe) begin
                $display("FAIL %s: pad_oe actual %02h expected %02h", it.tag, pad_oe, it.oe);
                bad = 1'b1;
            end
            if ((pad_do & it.do_mask) !== (it.dout & it.do_mask)) begin
                $display("FAIL %s: pad_do actual %02h expected %02h (mask %02h)",
                         it.tag, pad_do & it.do_mask, it.dout & it.do_mask, it.do_mask);
                bad = 1'b1;
            end
            if (it.clk_pin && (pad_do[2] !== sysclk)) begin
                $display("FAIL %s: pin2 actual %b expected clock %b", it.tag, pad_do[2], sysclk);
                bad = 1'b1;
            end
            if (bad) miscompares++;
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic expect_at(input logic [7:0] a, input logic [7:0] rd,
                             input logic [5:0] oe, input logic [5:0] dout,
                             input logic [5:0] mask, input bit clk_pin,
                             input string tag);
        sb_item_t it;
        bus_addr   = a;
        it.rd      = rd;
        it.oe      = oe;
        it.dout    = dout;
        it.do_mask = mask;
        it.clk_pin = clk_pin;
        it.tag     = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        // R2: direction cleared out of reset
        expect_at(8'h06, 8'h00, 6'h00, 6'h00, 6'h00, 0, "R2 reset dir");

        // R4 R1: all outputs
        bus_write(8'h02, 8'h2A);
        bus_write(8'h06, 8'h3F);
        expect_at(8'h02, 8'h2A, 6'h3F, 6'h2A, 6'h3F, 0, "R4 R1 all outputs");

        // R3: latch survives a reset pulse
        bus_write(8'h02, 8'h15);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        #1;
        expect_at(8'h06, 8'h00, 6'h00, 6'h15, 6'h3F, 0, "R2 dir after second reset");
        bus_write(8'h06, 8'h3F);
        expect_at(8'h02, 8'h15, 6'h3F, 6'h15, 6'h3F, 0, "R3 latch kept over reset");

        // R5: all inputs
        bus_write(8'h06, 8'h00);
        pad_di = 6'h2C;
        idle(3);
        expect_at(8'h02, 8'h2C, 6'h00, 6'h15, 6'h3F, 0, "R5 all inputs");

        // R5 R4: split direction, latch 0x2A, pins 0x15
        bus_write(8'h02, 8'h2A);
        pad_di = 6'h15;
        bus_write(8'h06, 8'h0F);
        idle(3);
        expect_at(8'h02, 8'h1A, 6'h0F, 6'h2A, 6'h3F, 0, "R5 split direction");

        // R6: two-edge synchronizer latency
        bus_write(8'h06, 8'h00);
        pad_di = 6'h00;
        idle(3);
        pad_di = 6'h3F;
        expect_at(8'h02, 8'h00, 6'h00, 6'h2A, 6'h3F, 0, "R6 zero edges");
        expect_at(8'h02, 8'h00, 6'h00, 6'h2A, 6'h3F, 0, "R6 one edge");
        expect_at(8'h02, 8'h3F, 6'h00, 6'h2A, 6'h3F, 0, "R6 two edges");

        // R8 R9: clock override, pin 2 reads the latch
        bus_write(8'h02, 8'h00);
        bus_write(8'h06, 8'h80);
        expect_at(8'h06, 8'h80, 6'h04, 6'h00, 6'h3B, 1, "R8 clkout enable readback");
        expect_at(8'h02, 8'h3B, 6'h04, 6'h00, 6'h3B, 1, "R9 pin2 reads latch");
        bus_write(8'h06, 8'h84);
        expect_at(8'h06, 8'h84, 6'h04, 6'h00, 6'h3B, 1, "R8 dir2 no effect");
        bus_write(8'h06, 8'h04);
        expect_at(8'h02, 8'h3B, 6'h04, 6'h00, 6'h3F, 0, "R8 override released");

        // R10: preload with pins as inputs
        bus_write(8'h06, 8'h00);
        bus_write(8'h02, 8'h33);
        expect_at(8'h06, 8'h00, 6'h00, 6'h33, 6'h00, 0, "R10 preload inputs");
        bus_write(8'h06, 8'h3F);
        expect_at(8'h02, 8'h33, 6'h3F, 6'h33, 6'h3F, 0, "R10 preload driven");

        // R7: reserved bits
        bus_write(8'h02, 8'hFF);
        expect_at(8'h02, 8'h3F, 6'h3F, 6'h3F, 6'h3F, 0, "R7 value reserved");
        bus_write(8'h06, 8'hFF);
        expect_at(8'h06, 8'hBF, 6'h3F, 6'h3F, 6'h3B, 1, "R7 dir reserved");

        // R11: unmapped offsets
        bus_write(8'h04, 8'h00);
        bus_write(8'h03, 8'h00);
        bus_write(8'h86, 8'h00);
        expect_at(8'h06, 8'hBF, 6'h3F, 6'h3F, 6'h3B, 1, "R11 dir untouched");
        expect_at(8'h02, 8'h3F, 6'h3F, 6'h3F, 6'h3B, 1, "R11 value untouched");
        expect_at(8'h04, 8'h00, 6'h3F, 6'h3F, 6'h3B, 1, "R11 unmapped read");

        idle(2);
        done = 1'b1;
        report();
    end

endmodule